// File: doc/BRIEF.md
# Non-Restoring Integer Square Root Unit

This block computes the integer square root of an unsigned radicand of `2*RootW` bits and returns a `RootW`-bit root equal to the floor of the real-valued square root. It is iterative: one root bit is resolved per clock cycle. A single add/subtract path updates a signed running remainder, the difference between the radicand and the square of the trial root. Shift registers hold a scaled copy of the trial root and a one-hot position marker. The trial root moves up or down by a power of two, chosen by the remainder's sign, and no restore step is taken.

A caller raises `start_i` for one cycle with the radicand on `radicand_i` while the unit is idle. The unit raises `busy_o` while it works. It then pulses `done_o` for one cycle with the result on `root_o`, which stays unchanged until the next result. When the remainder becomes exactly zero, an exact flag freezes it for the rest of the run. At the end, a one-step correction clears the low root bit when the remainder is still negative. That correction is safe because, in that case, the raw root is always odd.

Top module: `nrsqrt_unit`

## Requirements
- R1: On every `done_o` pulse, `root_o` satisfies root*root <= X < (root+1)*(root+1), where X is the radicand accepted by the matching start.
- R2: A start request made while `busy_o` is high is ignored: it neither restarts nor alters the current computation, and it queues no extra one.
- R3: When start is accepted at a rising edge, `busy_o` is high for exactly RootW cycles. `done_o` rises at the RootW-th rising edge after the accepting edge, stays high for exactly one cycle, and is never high together with `busy_o`.
- R4: `root_o` changes only in a cycle where `done_o` is high. It holds its value through idle cycles and through changes on `radicand_i`.
- R5: A radicand of zero gives a root of zero.
- R6: The all-ones radicand of 2*RootW bits gives the all-ones root of RootW bits.
- R7: For every k from 1 to 2^RootW-1, radicand k*k gives root k and radicand k*k-1 gives root k-1. An exact remainder of zero is held for the rest of the run.
- R8: While `rst_n` is low, `busy_o` and `done_o` are 0 and `root_o` is all zeros.
- R9: Changing `radicand_i` after the accepting edge has no effect on the result of the computation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| radicand_i | input | 2*RootW | Unsigned radicand, sampled at the accepting edge |
| busy_o | output | 1 | High while the iteration runs |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| root_o | output | RootW | Floor of the square root, held until the next result |

## Verification
The checker assumes that `radicand_i` matters only at the edge that accepts a start, and it keeps its own copy of the radicand taken at that edge. Its bounds check is therefore not disturbed when the stimulus deliberately changes the input during a run. It also assumes that `rst_n` is held for at least one clock edge before the first start. The bench honours this by releasing reset on a falling edge after several cycles and by driving every input on falling edges only. The bench makes its repeated and mid-run start requests only while `busy_o` is high, so the ignore rule is the only rule those requests can exercise.

// File: rtl/nrsqrt_pkg.sv
package nrsqrt_pkg;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_ITER = 1'b1
   } sq_state_e;

   localparam int unsigned SQ_MIN_ROOT_W = 2;
   localparam int unsigned SQ_MAX_ROOT_W = 32;

endpackage

// File: rtl/nrsqrt_ctrl.sv
module nrsqrt_ctrl
   import nrsqrt_pkg::*;
#(
   parameter int unsigned RootW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   output logic                  load_o,
   output logic                  step_o,
   output logic                  last_o,
   output logic                  busy_o,
   output logic [2*RootW-1:0]    bsel_o
);

   localparam int unsigned RadW   = 2 * RootW;
   localparam int unsigned TopPos = RadW - 2;

   sq_state_e          state_q;
   logic [RadW-1:0]    bsel_q;

   // accepted only when idle
   assign load_o = start_i && (state_q == SQ_IDLE);
   assign step_o = (state_q == SQ_ITER);
   // marker at root position 0 means this is the final level
   assign last_o = step_o && bsel_q[0];
   assign busy_o = step_o;
   assign bsel_o = bsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         bsel_q  <= '0;
      end else if (load_o) begin
         state_q <= SQ_ITER;
         bsel_q  <= RadW'(1) << TopPos;
      end else if (step_o) begin
         bsel_q  <= bsel_q >> 2;
         if (last_o) begin
            state_q <= SQ_IDLE;
         end
      end
   end

endmodule

// File: rtl/nrsqrt_remainder.sv
module nrsqrt_remainder #(
   parameter int unsigned RootW      = 8,
   parameter bit          EXACT_HOLD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  step_i,
   input  logic [2*RootW-1:0]    radicand_i,
   input  logic [2*RootW-1:0]    ys_i,
   input  logic [2*RootW-1:0]    bsel_i,
   output logic                  neg_o,
   output logic                  neg_next_o,
   output logic                  exact_o,
   output logic [2*RootW+1:0]    diff_o
);

   localparam int unsigned RadW  = 2 * RootW;
   localparam int unsigned DiffW = RadW + 2;
   localparam int unsigned SignB = DiffW - 1;

   logic [DiffW-1:0] diff_q;
   logic [DiffW-1:0] ys_w;
   logic [DiffW-1:0] b_w;
   logic [DiffW-1:0] opnd_w;
   logic [DiffW-1:0] addend_w;
   logic [DiffW-1:0] sum_w;
   logic [DiffW-1:0] diff_reg_nx;
   logic             hold_w;
   logic             upd_w;

   assign ys_w  = {2'b00, ys_i};
   assign b_w   = {2'b00, bsel_i};
   assign neg_o = diff_q[SignB];

   // Operand formed by masking only. The scaled root has its lowest set bit
   // two places above the marker whenever the remainder can be negative, so
   // subtracting the marker is a clear plus two sets.
   always_comb begin
      if (neg_o) begin
         opnd_w = (ys_w & ~(b_w << 2)) | (b_w << 1) | b_w;
      end else begin
         opnd_w = ys_w | b_w;
      end
   end

   // the single shared adder/subtracter: invert and carry-in for subtraction
   assign addend_w = neg_o ? opnd_w : ~opnd_w;
   assign sum_w    = diff_q + addend_w + {{(DiffW-1){1'b0}}, ~neg_o};

   assign upd_w       = step_i && !hold_w;
   assign diff_reg_nx = upd_w ? sum_w : diff_q;
   assign neg_next_o  = diff_reg_nx[SignB];
   assign diff_o      = diff_q;
   assign exact_o     = hold_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diff_q <= '0;
      end else if (load_i) begin
         diff_q <= {2'b00, radicand_i};
      end else if (upd_w) begin
         diff_q <= sum_w;
      end
   end

   generate
      if (EXACT_HOLD) begin : g_exact
         logic exact_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exact_q <= 1'b0;
            end else if (load_i) begin
               exact_q <= 1'b0;
            end else if (upd_w && (sum_w == '0)) begin
               exact_q <= 1'b1;
            end
         end
         assign hold_w = exact_q;
      end else begin : g_no_exact
         assign hold_w = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/nrsqrt_rootshift.sv
module nrsqrt_rootshift #(
   parameter int unsigned RootW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  step_i,
   input  logic                  neg_i,
   input  logic                  hold_i,
   input  logic [2*RootW-1:0]    bsel_i,
   output logic [2*RootW-1:0]    ys_o,
   output logic [RootW-1:0]      root_nx_o
);

   localparam int unsigned RadW = 2 * RootW;

   logic [RadW-1:0] ys_q;
   logic [RadW-1:0] half_w;
   logic [RadW-1:0] ys_nx;

   assign half_w = ys_q >> 1;

   // Scaled root: trial root shifted up by (level+1). Moving one level down
   // halves it; the +/- step of 2^level becomes a set, or a clear-and-set.
   always_comb begin
      if (hold_i) begin
         ys_nx = half_w;
      end else if (neg_i) begin
         ys_nx = (half_w & ~(bsel_i << 1)) | bsel_i;
      end else begin
         ys_nx = half_w | bsel_i;
      end
   end

   assign ys_o      = ys_q;
   assign root_nx_o = ys_nx[RootW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ys_q <= '0;
      end else if (load_i) begin
         ys_q <= '0;
      end else if (step_i) begin
         ys_q <= ys_nx;
      end
   end

endmodule

// File: rtl/nrsqrt_unit.sv
module nrsqrt_unit
   import nrsqrt_pkg::*;
#(
   parameter int unsigned RootW      = 8,
   parameter bit          EXACT_HOLD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [2*RootW-1:0]    radicand_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [RootW-1:0]      root_o
);

   localparam int unsigned RadW  = 2 * RootW;
   localparam int unsigned DiffW = RadW + 2;

   generate
      if (RootW < SQ_MIN_ROOT_W || RootW > SQ_MAX_ROOT_W) begin : g_bad_width
         $error("nrsqrt_unit: RootW out of supported range");
      end
   endgenerate

   logic                load_w;
   logic                step_w;
   logic                last_w;
   logic [RadW-1:0]     bsel_w;
   logic [RadW-1:0]     ys_w;
   logic [RootW-1:0]    root_nx_w;
   logic                neg_w;
   logic                neg_next_w;
   logic                exact_w;
   logic [DiffW-1:0]    diff_w;
   logic [RootW-1:0]    root_q;
   logic                done_q;

   nrsqrt_ctrl #(.RootW(RootW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load_w),
      .step_o  (step_w),
      .last_o  (last_w),
      .busy_o  (busy_o),
      .bsel_o  (bsel_w)
   );

   nrsqrt_remainder #(.RootW(RootW), .EXACT_HOLD(EXACT_HOLD)) u_rem (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_w),
      .step_i     (step_w),
      .radicand_i (radicand_i),
      .ys_i       (ys_w),
      .bsel_i     (bsel_w),
      .neg_o      (neg_w),
      .neg_next_o (neg_next_w),
      .exact_o    (exact_w),
      .diff_o     (diff_w)
   );

   nrsqrt_rootshift #(.RootW(RootW)) u_root (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_w),
      .step_i    (step_w),
      .neg_i     (neg_w),
      .hold_i    (exact_w),
      .bsel_i    (bsel_w),
      .ys_o      (ys_w),
      .root_nx_o (root_nx_w)
   );

   // final correction: a negative remainder means the odd raw root is one high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_w;
         if (last_w) begin
            root_q <= root_nx_w & ~(RootW'(neg_next_w));
         end
      end
   end

   assign root_o = root_q;
   assign done_o = done_q;

endmodule

// File: rtl/nrsqrt_unit_chk.sv
module nrsqrt_unit_chk #(
   parameter int unsigned RootW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [2*RootW-1:0]    radicand_i,
   input  logic                  busy_o,
   input  logic                  done_o,
   input  logic [RootW-1:0]      root_o,
   input  logic [2*RootW-1:0]    bsel,
   input  logic                  exact,
   input  logic [2*RootW+1:0]    diff
);

   localparam int unsigned RadW = 2 * RootW;
   localparam int unsigned ExtW = RadW + 2;

   logic [RadW-1:0]  cap_q;
   logic [7:0]       cnt_q;
   logic [ExtW-1:0]  r_ext;
   logic [ExtW-1:0]  r_inc;
   logic [ExtW-1:0]  sq_lo;
   logic [ExtW-1:0]  sq_hi;
   logic [ExtW-1:0]  cap_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
         cnt_q <= '0;
      end else if (start_i && !busy_o) begin
         cap_q <= radicand_i;
         cnt_q <= '0;
      end else if (busy_o) begin
         cnt_q <= cnt_q + 8'd1;
      end
   end

   assign r_ext   = ExtW'(root_o);
   assign r_inc   = r_ext + ExtW'(1);
   assign sq_lo   = r_ext * r_ext;
   assign sq_hi   = r_inc * r_inc;
   assign cap_ext = ExtW'(cap_q);

   a_r1_floor_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((sq_lo <= cap_ext) && (sq_hi > cap_ext)));

   a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cnt_q == 8'(RootW)));

   a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r3_marker_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> $onehot(bsel));

   a_r4_root_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(root_o) |-> done_o);

   a_r7_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
      exact |-> (diff == '0));

endmodule

bind nrsqrt_unit nrsqrt_unit_chk #(.RootW(RootW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .radicand_i (radicand_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .root_o     (root_o),
   .bsel       (bsel_w),
   .exact      (exact_w),
   .diff       (diff_w)
);

// File: tb/sim_nrsqrt_unit.sv
`timescale 1ns/1ps
module sim_nrsqrt_unit;

   localparam int unsigned RW   = 8;
   localparam int unsigned RadW = 2 * RW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [RadW-1:0] radicand_i = '0;
   logic            busy_o;
   logic            done_o;
   logic [RW-1:0]   root_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   nrsqrt_unit #(.RootW(RW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .radicand_i (radicand_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .root_o     (root_o)
   );

   function automatic longint isq(input longint x);
      longint r = 0;
      while ((r + 1) * (r + 1) <= x) r++;
      return r;
   endfunction

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_sqrt(input logic [RadW-1:0] x,
                           output logic [RW-1:0] r, output int lat);
      @(negedge clk);
      start_i    = 1'b1;
      radicand_i = x;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 4 * RW) begin
         @(negedge clk);
         lat++;
      end
      r = root_o;
   endtask

   task automatic t_reset;
      check("R8", "busy in reset", longint'(busy_o), 0);
      check("R8", "done in reset", longint'(done_o), 0);
      check("R8", "root in reset", longint'(root_o), 0);
   endtask

   task automatic t_edges;
      logic [RW-1:0] r;
      int lat;
      run_sqrt('0, r, lat);
      check("R5", "zero radicand", longint'(r), 0);
      run_sqrt({RadW{1'b1}}, r, lat);
      check("R6", "all-ones radicand", longint'(r), longint'({RW{1'b1}}));
   endtask

   task automatic t_latency;
      logic [RW-1:0] r;
      int lat;
      run_sqrt(RadW'(1000), r, lat);
      check("R3", "done latency", longint'(lat), longint'(RW));
      check("R3", "busy low with done", longint'(busy_o), 0);
      check("R1", "root of 1000", longint'(r), isq(1000));
      @(negedge clk);
      check("R3", "done width one cycle", longint'(done_o), 0);
   endtask

   task automatic t_sweep;
      logic [RW-1:0] r;
      int lat;
      for (int x = 0; x < 1500; x++) begin
         run_sqrt(RadW'(x), r, lat);
         check("R1", $sformatf("sweep x=%0d", x), longint'(r), isq(x));
      end
   endtask

   task automatic t_squares;
      logic [RW-1:0] r;
      int lat;
      for (int k = 1; k < (1 << RW); k++) begin
         run_sqrt(RadW'(k * k), r, lat);
         check("R7", $sformatf("square k=%0d", k), longint'(r), longint'(k));
         run_sqrt(RadW'(k * k - 1), r, lat);
         check("R7", $sformatf("below square k=%0d", k), longint'(r), longint'(k - 1));
      end
   endtask

   task automatic t_busy_ignore;
      logic [RadW-1:0] x1 = RadW'(50000);
      logic [RadW-1:0] x2 = RadW'(30);
      int lat = 0;
      @(negedge clk);
      start_i    = 1'b1;
      radicand_i = x1;
      @(negedge clk);
      radicand_i = x2;
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 4 * RW) begin
         @(negedge clk);
         lat++;
      end
      check("R2", "latency with repeat start", longint'(lat), longint'(RW));
      check("R9", "result after input change", longint'(root_o), isq(longint'(x1)));
      @(negedge clk);
      check("R2", "no queued run busy", longint'(busy_o), 0);
      repeat (RW + 2) @(negedge clk);
      check("R2", "no queued run done", longint'(done_o), 0);
   endtask

   task automatic t_hold;
      logic [RW-1:0] r;
      int lat;
      run_sqrt(RadW'(4000), r, lat);
      repeat (3) @(negedge clk);
      radicand_i = RadW'(9);
      repeat (4) @(negedge clk);
      check("R4", "root held while idle", longint'(root_o), isq(4000));
      check("R4", "done stays low", longint'(done_o), 0);
   endtask

   task automatic t_random;
      logic [RW-1:0] r;
      int lat;
      logic [31:0] s = 32'h1234_5678;
      for (int n = 0; n < 400; n++) begin
         s = s * 32'd1664525 + 32'd1013904223;
         run_sqrt(s[31:32-RadW], r, lat);
         check("R1", "random radicand", longint'(r), isq(longint'(s[31:32-RadW])));
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_latency;
      t_edges;
      t_busy_ignore;
      t_hold;
      t_sweep;
      t_squares;
      t_random;
      finish_run;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end

endmodule